// File: doc/BRIEF.md
# Multi-Source Reset Sequence Controller

This block gathers three reset requests into one internal reset for an 8-bit microcontroller core and then releases the core through a fixed three-phase sequence. The requests are a pulse on the bidirectional reset pin, a level from the supply-voltage monitor, and a one-cycle timeout from the watchdog. While the first phase runs, the block pulls the reset pin low through an open-drain style enable. This tells the rest of the board that a reset is in progress.

After the first phase, whose length depends on which source won, the block waits a fixed 4096 CPU clocks so that the oscillator can settle. It then reads the two reset-vector bytes from the bus, high byte first. In the cycle after the second read it releases the core and presents the assembled 16-bit start address with a one-cycle strobe. A new request at any point throws the sequence back to its first phase. A small sticky register tells software which source caused the last reset. Software clears a bit by writing 1 to it.

Top module: `rstseq_ctrl`

## Requirements
- R1: Three request sources are accepted: the synchronised reset pin, `lvd_flag` and `wdg_timeout`. When several are active in the same cycle, the priority is low-voltage first, then watchdog, then pin. The cause bits are: bit 0 = pin, bit 1 = watchdog, bit 2 = low-voltage.
- R2: `pin_drive_low` is high for exactly the cycles of phase 1, and `core_reset_n` is low for every cycle of phases 1, 2 and 3.
- R3: Phase 1 lasts 16 cycles for a pin request and 64 cycles for a watchdog request. For a low-voltage request it lasts as long as the flag is sampled high, and then ends on the 16th clock edge at which the flag is sampled low. If the flag is seen high at H edges, the pin is driven for H+15 cycles.
- R4: Phase 2 lasts exactly 4096 cycles. During phase 2 the pin is not driven and there is no bus read.
- R5: Phase 3 is two cycles with `bus_rd` high. `bus_addr` is 16'hFFFE in the first cycle and 16'hFFFF in the second. The byte read in the first cycle is the high byte and the byte read in the second cycle is the low byte.
- R6: `core_reset_n` rises in the cycle right after the second read. In that same cycle `pc_load_valid` is high for one cycle and `pc_load` holds {high byte, low byte}.
- R7: A request in any phase, and also while the core runs, restarts phase 1 with a fresh count. No strobe is given for the abandoned sequence.
- R8: `pin_in` passes through a two-flop synchroniser. A low level there counts as a request only if the block is not driving the pin and has not driven it in either of the two previous cycles. The block's own drive therefore never restarts the sequence.
- R9: `cause` is sticky. A write with `cause_wr` clears the bits set to 1 in `cause_wdata`. A request in the same cycle wins over a clear of its own bit.
- R10: While `por_n` is low, the block sits in phase 1 with the pin-request length and `cause` = 0. After `por_n` rises, a full sequence follows with 16 cycles of pin drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | 1 | Level read back from the reset pin |
| pin_drive_low | output | 1 | Enable that pulls the reset pin low |
| lvd_flag | input | 1 | Low-voltage-detect request, level |
| wdg_timeout | input | 1 | Watchdog timeout request |
| bus_addr | output | 16 | Vector fetch address |
| bus_rd | output | 1 | Vector fetch read strobe |
| bus_rdata | input | 8 | Byte returned by the bus |
| core_reset_n | output | 1 | Core reset, active low |
| pc_load | output | 16 | Fetched reset vector |
| pc_load_valid | output | 1 | One-cycle strobe for pc_load |
| cause | output | 3 | Sticky reset cause |
| cause_wr | input | 1 | Write strobe for cause clear |
| cause_wdata | input | 3 | Write-1-to-clear mask |

## Verification
The hardest situations to reach are restarts that arrive deep inside the 4096-cycle phase, and a low-voltage request that lands in the same cycle as a watchdog timeout. The stimulus waits a random number of cycles into phase 2 before it fires a second source, and it fires both internal sources on one edge to check priority. Ignoring the block's own pin drive cannot be seen directly. The bench models the pin as a wired-low net that is fed back into `pin_in`, and requires every sequence to keep an exact phase-2 length, which a self-restart would break.

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl #(
  parameter int          STAB_CYCLES = 4096,
  parameter int          PIN_DELAY   = 16,
  parameter int          WDG_DELAY   = 64,
  parameter int          LVD_TAIL    = 16,
  parameter logic [15:0] VEC_ADDR    = 16'hFFFE
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        pin_in,
  output logic        pin_drive_low,
  input  logic        lvd_flag,
  input  logic        wdg_timeout,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  input  logic [7:0]  bus_rdata,
  output logic        core_reset_n,
  output logic [15:0] pc_load,
  output logic        pc_load_valid,
  output logic [2:0]  cause,
  input  logic        cause_wr,
  input  logic [2:0]  cause_wdata
);

  localparam int M1   = (PIN_DELAY > WDG_DELAY) ? PIN_DELAY : WDG_DELAY;
  localparam int M2   = (M1 > LVD_TAIL) ? M1 : LVD_TAIL;
  localparam int MAXC = (M2 > STAB_CYCLES) ? M2 : STAB_CYCLES;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYCLES - 1);
  localparam logic [CW-1:0] PIN_LAST  = CW'(PIN_DELAY - 1);
  localparam logic [CW-1:0] WDG_LAST  = CW'(WDG_DELAY - 1);
  localparam logic [CW-1:0] LVD_LAST  = CW'(LVD_TAIL - 1);

  typedef enum logic [2:0] {S_RUN, S_DLY, S_STAB, S_FHI, S_FLO} st_t;
  typedef enum logic [1:0] {SRC_PIN, SRC_WDG, SRC_LVD} src_t;

  st_t           st;
  src_t          src, sel;
  logic [CW-1:0] cnt, dly_last;
  logic [1:0]    sync, drv_h;
  logic [7:0]    hi_q;
  logic          ext_req, any_req;
  logic [2:0]    set_bits, clr_bits;

  assign pin_drive_low = (st == S_DLY);
  assign core_reset_n  = (st == S_RUN);
  assign bus_rd        = (st == S_FHI) || (st == S_FLO);
  assign bus_addr      = (st == S_FHI) ? VEC_ADDR :
                         (st == S_FLO) ? (VEC_ADDR | 16'h0001) : 16'h0000;

  assign ext_req  = !sync[1] && !pin_drive_low && (drv_h == 2'b00);
  assign any_req  = ext_req || wdg_timeout || lvd_flag;
  assign sel      = lvd_flag ? SRC_LVD : (wdg_timeout ? SRC_WDG : SRC_PIN);
  assign dly_last = (src == SRC_LVD) ? LVD_LAST :
                    (src == SRC_WDG) ? WDG_LAST : PIN_LAST;

  assign set_bits = !any_req ? 3'b000 :
                    (sel == SRC_LVD) ? 3'b100 :
                    (sel == SRC_WDG) ? 3'b010 : 3'b001;
  assign clr_bits = cause_wr ? cause_wdata : 3'b000;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync  <= 2'b11;
      drv_h <= 2'b11;
    end else begin
      sync  <= {sync[0], pin_in};
      drv_h <= {drv_h[0], pin_drive_low};
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st            <= S_DLY;
      src           <= SRC_PIN;
      cnt           <= '0;
      hi_q          <= 8'h00;
      pc_load       <= 16'h0000;
      pc_load_valid <= 1'b0;
    end else begin
      pc_load_valid <= 1'b0;
      if (any_req) begin
        st  <= S_DLY;
        src <= sel;
        cnt <= '0;
      end else begin
        case (st)
          S_DLY: begin
            if (cnt == dly_last) begin
              st  <= S_STAB;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STAB: begin
            if (cnt == STAB_LAST) begin
              st  <= S_FHI;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_FHI: begin
            hi_q <= bus_rdata;
            st   <= S_FLO;
          end
          S_FLO: begin
            pc_load       <= {hi_q, bus_rdata};
            pc_load_valid <= 1'b1;
            st            <= S_RUN;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause <= 3'b000;
    else        cause <= (cause & ~clr_bits) | set_bits;
  end

endmodule

module rstseq_ctrl_chk #(
  parameter int STAB_CYCLES = 4096
) (
  input logic        clk,
  input logic        por_n,
  input logic        pin_drive_low,
  input logic        core_reset_n,
  input logic        bus_rd,
  input logic [15:0] bus_addr,
  input logic        pc_load_valid,
  input logic [2:0]  cause,
  input logic        cause_wr
);
  int  run_len;
  logic stab_like;
  assign stab_like = !pin_drive_low && !core_reset_n && !bus_rd;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) run_len <= 0;
    else        run_len <= stab_like ? run_len + 1 : 0;
  end

  AST_DRIVE_HOLDS_CORE: assert property (@(posedge clk) disable iff (!por_n)
    pin_drive_low |-> !core_reset_n); // R2
  AST_STAB_BOUND: assert property (@(posedge clk) disable iff (!por_n)
    run_len <= STAB_CYCLES); // R4
  AST_STAB_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!por_n)
    $rose(bus_rd) |-> (run_len == STAB_CYCLES)); // R4
  AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!por_n)
    (bus_rd && bus_addr == 16'hFFFE) |=> ((bus_rd && bus_addr == 16'hFFFF) || pin_drive_low)); // R5
  AST_RELEASE_STROBE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_reset_n) |-> pc_load_valid); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    pc_load_valid |=> !pc_load_valid); // R6
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    !cause_wr |=> ((cause & $past(cause)) == $past(cause))); // R9
endmodule

bind rstseq_ctrl rstseq_ctrl_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (
  .clk(clk), .por_n(por_n), .pin_drive_low(pin_drive_low),
  .core_reset_n(core_reset_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .pc_load_valid(pc_load_valid), .cause(cause), .cause_wr(cause_wr));

// File: tb/rstseq_ctrl_tb.sv
module rstseq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        ext_low = 1'b0;
  logic        lvd_flag = 1'b0;
  logic        wdg_timeout = 1'b0;
  logic        cause_wr = 1'b0;
  logic [2:0]  cause_wdata = 3'b000;
  logic [7:0]  vec_hi = 8'h12, vec_lo = 8'h34;
  logic        pin_in, pin_drive_low, bus_rd, core_reset_n, pc_load_valid;
  logic [15:0] bus_addr, pc_load;
  logic [7:0]  bus_rdata;
  logic [2:0]  cause;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pin_in    = !(pin_drive_low || ext_low);
  assign bus_rdata = (bus_addr == 16'hFFFE) ? vec_hi :
                     (bus_addr == 16'hFFFF) ? vec_lo : 8'h00;

  rstseq_ctrl u_dut (
    .clk(clk), .por_n(por_n), .pin_in(pin_in), .pin_drive_low(pin_drive_low),
    .lvd_flag(lvd_flag), .wdg_timeout(wdg_timeout), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .core_reset_n(core_reset_n),
    .pc_load(pc_load), .pc_load_valid(pc_load_valid), .cause(cause),
    .cause_wr(cause_wr), .cause_wdata(cause_wdata));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_drive(input int src, input int h);
    if (src == 2) return h + 16 - 1;
    if (src == 1) return 64;
    return 16;
  endfunction

  function automatic logic [2:0] cause_bit(input int src);
    return 3'b001 << src;
  endfunction

  task automatic measure(input int exp_d, input string tag);
    int n = 0;
    int g = 0;
    while (!pin_drive_low && g < 300) begin @(negedge clk); g++; end
    while (pin_drive_low && n < 100000) begin
      chk(!core_reset_n, "R2", {tag, " core held during drive"}, core_reset_n, 0);
      n++; @(negedge clk);
    end
    chk(n == exp_d, "R3", {tag, " phase1 drive length"}, n, exp_d);
    n = 0;
    while (!core_reset_n && !bus_rd && !pin_drive_low && n < 10000) begin n++; @(negedge clk); end
    chk(n == 4096, "R4", {tag, " stabilisation length (R8 no self restart)"}, n, 4096);
    chk(bus_rd && bus_addr == 16'hFFFE, "R5", {tag, " first fetch addr"}, bus_addr, 16'hFFFE);
    chk(!core_reset_n, "R2", {tag, " core low in fetch"}, core_reset_n, 0);
    @(negedge clk);
    chk(bus_rd && bus_addr == 16'hFFFF, "R5", {tag, " second fetch addr"}, bus_addr, 16'hFFFF);
    @(negedge clk);
    chk(core_reset_n && pc_load_valid, "R6", {tag, " release with strobe"},
        {core_reset_n, pc_load_valid}, 2'b11);
    chk(pc_load == {vec_hi, vec_lo}, "R6", {tag, " vector"}, pc_load, {vec_hi, vec_lo});
    @(negedge clk);
    chk(core_reset_n && !pc_load_valid, "R6", {tag, " strobe one cycle"},
        {core_reset_n, pc_load_valid}, 2'b10);
  endtask

  task automatic fire(input int src, input int h);
    if (src == 0) begin
      ext_low = 1'b1; repeat (h) @(negedge clk); ext_low = 1'b0;
    end else if (src == 1) begin
      wdg_timeout = 1'b1; @(negedge clk); wdg_timeout = 1'b0;
    end else begin
      lvd_flag = 1'b1; repeat (h) @(negedge clk); lvd_flag = 1'b0;
    end
  endtask

  task automatic clear_cause(input logic [2:0] m);
    cause_wr = 1'b1; cause_wdata = m; @(negedge clk);
    cause_wr = 1'b0; cause_wdata = 3'b000;
  endtask

  task automatic seq(input int src, input int h, input string tag);
    fork
      fire(src, h);
      measure(exp_drive(src, h), tag);
    join
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(pin_drive_low && !core_reset_n, "R10", "reset state drive/core",
        {pin_drive_low, core_reset_n}, 2'b10);
    chk(cause == 3'b000, "R10", "reset cause", cause, 0);
    por_n = 1'b1;
    measure(16, "R10 power-on");

    clear_cause(3'b111);
    seq(0, 3, "R1 R8 pin");
    chk(cause == 3'b001, "R1", "pin cause", cause, 3'b001);
    seq(1, 1, "R1 watchdog");
    chk(cause == 3'b011, "R9", "sticky cause", cause, 3'b011);
    seq(2, 7, "R3 lvd");
    chk(cause == 3'b111, "R1", "lvd cause", cause, 3'b111);

    clear_cause(3'b010);
    chk(cause == 3'b101, "R9", "w1c single bit", cause, 3'b101);
    clear_cause(3'b000);
    chk(cause == 3'b101, "R9", "zero write no effect", cause, 3'b101);
    clear_cause(3'b111);

    fork
      begin wdg_timeout = 1'b1; lvd_flag = 1'b1; @(negedge clk);
            wdg_timeout = 1'b0; lvd_flag = 1'b0; end
      measure(16, "R1 priority");
    join
    chk(cause == 3'b100, "R1", "priority cause", cause, 3'b100);

    clear_cause(3'b111);
    fire(1, 1);
    repeat (64 + 10 + ($urandom % 3900)) begin
      @(negedge clk);
      chk(!core_reset_n && !pc_load_valid, "R7", "no release before restart",
          {core_reset_n, pc_load_valid}, 0);
    end
    seq(0, 2, "R7 restart in stab");
    chk(cause == 3'b011, "R7", "restart cause", cause, 3'b011);

    fire(1, 1);
    repeat (64 + 4096) @(negedge clk);
    chk(bus_rd && bus_addr == 16'hFFFE, "R5", "reached fetch", bus_addr, 16'hFFFE);
    seq(2, 2, "R7 restart in fetch");

    for (int i = 0; i < 6; i++) begin
      int s = int'($urandom % 3);
      int h = 1 + int'($urandom % 20);
      vec_hi = 8'($urandom); vec_lo = 8'($urandom);
      clear_cause(3'b111);
      repeat (1 + ($urandom % 5)) @(negedge clk);
      seq(s, h, "R3 random");
      chk(cause == cause_bit(s), "R1", "random cause", cause, cause_bit(s));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule